// File: doc/BRIEF.md
# Tiled Neighborhood Pattern Test Sequencer

This block is a built-in self-test controller for a bit-wide RAM laid out as a grid of `ROWS` by `COLS` cells. It targets static faults in which a cell is forced to a wrong value by the contents of the four cells next to it: the cells above, below, left and right. It drives the RAM address, write data, write strobe and read strobe directly. It compares each read against the value it expects and reports busy, done, a sticky fail flag and the address of the first cell that read back wrong.

Every cell gets a label `(row + 2*col) mod 5`. Under this labelling the four neighbours of any cell carry the four other labels. One label is chosen as the base set. The other four labels are then stepped through all sixteen patterns along a reflected Gray code, so only one neighbour position changes between patterns. Each pattern change therefore costs a single write sweep over the cells of one label, followed by a read sweep over the base cells. The base set is rotated over all five labels, so every cell is checked as a base cell with each of its neighbours in each possible state.

The RAM is synchronous: read data for a strobed address arrives on the next cycle. Cells outside the grid do not exist. Border cells simply have fewer neighbours, and nothing wraps around the edges.

Top module: `nbr_pattern_bist`

## Requirements
- R1: After reset, or whenever `rst_ni` is low, `busy_o`, `done_o`, `fail_o`, `mem_we_o` and `mem_re_o` are all 0.
- R2: A `start_i` sampled while idle or done makes `busy_o` high from the next cycle. From then on exactly one memory operation is issued per cycle, with no gaps. After the last operation there is one cycle with `busy_o` high and no strobe. Then `done_o` goes high and stays high until the next start. A `start_i` sampled while busy has no effect.
- R3: Address is `row*COLS + col`. In round b, the base cells are the cells with label b. Offset +1 is the south neighbour, +2 east, +3 west and +4 north, each taken mod 5. A base read sweep reads every label-b cell and expects the current phase value (0 in phase 0, 1 in phase 1).
- R4: Each round starts by writing 0 to every cell in ascending address order.
- R5: A label sweep visits only the in-grid cells whose label matches, in ascending address order. Border cells get no wrapped or out-of-range access, and every strobed address is below `ROWS*COLS`.
- R6: Phase 0 is one base read sweep, then fifteen steps for j = 1..15. With g(j) = j ^ (j>>1), step j writes the cells at offset p+1, where p is the single bit in which g(j-1) and g(j) differ. The value written is bit p of g(j). Each write sweep is followed by a base read sweep.
- R7: Phase 1 writes 1 to all label-b cells, does one base read sweep, then walks j = 15 down to 1. Each step writes the offset of the bit that differs between g(j) and g(j-1), with that bit's value in g(j-1), and is followed by a base read sweep.
- R8: Rounds run for b = 0, 1, 2, 3, 4 in that order, each made of the fill, phase 0 and phase 1. The test ends after round 4.
- R9: `mem_rdata_i` is compared one cycle after `mem_re_o`. On the first mismatch `fail_o` goes high and `fail_addr_o` takes the address that was read. Later mismatches leave both unchanged, and the test runs on to done.
- R10: An accepted start clears `fail_o` and `fail_addr_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a test run |
| mem_addr_o | output | AW | RAM cell address |
| mem_we_o | output | 1 | RAM write strobe |
| mem_re_o | output | 1 | RAM read strobe |
| mem_wdata_o | output | 1 | RAM write data |
| mem_rdata_i | input | 1 | RAM read data, valid the cycle after a read strobe |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | Test finished, held until next start |
| fail_o | output | 1 | At least one read mismatched |
| fail_addr_o | output | AW | Address of the first mismatching read |

## Verification
The bench builds the full expected operation stream from the labelling and the Gray walk, and compares it cycle by cycle. It uses a 6-by-7 grid, whose width is not a multiple of five. A design that wrapped label sweeps across the border, or restarted the column offset wrongly on a new row, would strobe a wrong address at once. It injects a stuck-at-1 fault in the first corner cell, a stuck-at-0 fault in the last corner cell, and a fault that appears only when all four neighbours hold 1 with the base at 1. A design that skipped the descending phase or mapped a Gray bit to the wrong neighbour would miss the last of these. The stuck corner cell mismatches on sixteen reads, so a capture that was not sticky would report a later read. A start pulse in the middle of a run checks that the run is not restarted. Running a fault-free test after a failing one checks that the fail capture is cleared.

// File: rtl/nbp_pkg.sv
package nbp_pkg;
  localparam int unsigned NBR_CELLS = 5;
  localparam int unsigned NBR_BITS  = NBR_CELLS - 1;
  localparam int unsigned PAT_LAST  = (1 << NBR_BITS) - 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FILL, ST_SET, ST_READ, ST_WRITE, ST_DRAIN, ST_DONE
  } state_e;

  // valid for v < 15
  function automatic logic [2:0] mod5(input logic [4:0] v);
    logic [4:0] t;
    t = v;
    if (t >= 5'd10) t = t - 5'd10;
    if (t >= 5'd5)  t = t - 5'd5;
    return t[2:0];
  endfunction
endpackage

// File: rtl/nbp_cell_walker.sv
module nbp_cell_walker
  import nbp_pkg::*;
#(
  parameter int unsigned ROWS = 16,
  parameter int unsigned COLS = 16,
  parameter int unsigned AW   = $clog2(ROWS*COLS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          full_i,
  input  logic [2:0]    label_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  localparam int unsigned RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int unsigned CW = (COLS > 1) ? $clog2(COLS) : 1;

  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic [AW-1:0] base_q;
  logic [2:0]    c0_q, lbl_q, c0_first, c0_next;
  logic          full_q;

  // first column of label L on row 0 is 3L mod 5; each row shifts it by +2
  assign c0_first = mod5({1'b0, label_i, 1'b0} + {2'b00, label_i});
  assign c0_next  = mod5({2'b00, c0_q} + 5'd2);

  always_comb begin
    if (full_q) last_o = (int'(row_q) == int'(ROWS) - 1) && (int'(col_q) == int'(COLS) - 1);
    else        last_o = (int'(row_q) == int'(ROWS) - 1) && (int'(col_q) + 5 >= int'(COLS));
  end

  assign addr_o = base_q + AW'(col_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      col_q  <= '0;
      base_q <= '0;
      c0_q   <= '0;
      lbl_q  <= '0;
      full_q <= 1'b1;
    end else if (load_i) begin
      row_q  <= '0;
      base_q <= '0;
      full_q <= full_i;
      lbl_q  <= label_i;
      c0_q   <= c0_first;
      col_q  <= full_i ? '0 : CW'(c0_first);
    end else if (step_i) begin
      if (full_q) begin
        if (int'(col_q) == int'(COLS) - 1) begin
          col_q  <= '0;
          row_q  <= row_q + 1'b1;
          base_q <= base_q + AW'(COLS);
        end else begin
          col_q <= col_q + 1'b1;
        end
      end else if (int'(col_q) + 5 < int'(COLS)) begin
        col_q <= col_q + CW'(5);
      end else begin
        row_q  <= row_q + 1'b1;
        base_q <= base_q + AW'(COLS);
        c0_q   <= c0_next;
        col_q  <= CW'(c0_next);
      end
    end
  end

  assert_label_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_q |-> ((int'(row_q) + 2 * int'(col_q)) % 5) == int'(lbl_q));

  assert_in_grid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(row_q) < int'(ROWS)) && (int'(col_q) < int'(COLS)));
endmodule

// File: rtl/nbp_gray_step.sv
module nbp_gray_step
  import nbp_pkg::*;
(
  input  logic [2:0] round_i,
  input  logic [3:0] idx_i,
  input  logic       rising_i,
  output logic [2:0] label_o,
  output logic       value_o
);
  logic [4:0] tr;
  logic [3:0] g;
  logic [1:0] pos;

  always_comb begin
    // transition index: idx-1 -> idx when rising, idx+1 -> idx when falling
    tr  = rising_i ? {1'b0, idx_i} : ({1'b0, idx_i} + 5'd1);
    g   = idx_i ^ (idx_i >> 1);
    pos = 2'd0;
    for (int p = 3; p >= 0; p--) begin
      if (tr[p]) pos = 2'(p);
    end
    value_o = g[pos];
    label_o = mod5({2'b00, round_i} + {3'b000, pos} + 5'd1);
  end
endmodule

// File: rtl/nbp_read_check.sv
module nbp_read_check #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          re_i,
  input  logic          exp_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rdata_i,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o
);
  logic          pend_q, exp_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      exp_q       <= 1'b0;
      addr_q      <= '0;
      fail_o      <= 1'b0;
      fail_addr_o <= '0;
    end else begin
      pend_q <= re_i;
      exp_q  <= exp_i;
      addr_q <= addr_i;
      if (clr_i) begin
        fail_o      <= 1'b0;
        fail_addr_o <= '0;
      end else if (pend_q && (rdata_i != exp_q) && !fail_o) begin
        fail_o      <= 1'b1;
        fail_addr_o <= addr_q;
      end
    end
  end

  assert_fail_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !clr_i) |=> (fail_o && $stable(fail_addr_o)));

  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!fail_o && fail_addr_o == '0));
endmodule

// File: rtl/nbr_pattern_bist.sv
module nbr_pattern_bist
  import nbp_pkg::*;
#(
  parameter int unsigned ROWS = 16,
  parameter int unsigned COLS = 16,
  localparam int unsigned CELLS = ROWS * COLS,
  localparam int unsigned AW    = $clog2(CELLS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic          mem_wdata_o,
  input  logic          mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o
);
  localparam logic [2:0] LAST_ROUND = 3'(NBR_CELLS - 1);
  localparam logic [3:0] IDX_LAST   = 4'(PAT_LAST);

  state_e     st_q, st_d;
  logic [2:0] round_q, round_d;
  logic [3:0] idx_q, idx_d;
  logic       ph_q, ph_d, wval_q;
  logic       load, step, clr, last;
  logic [2:0] gs_label, walk_label;
  logic       gs_val, walk_full, op_act;

  assign op_act = (st_q == ST_FILL) || (st_q == ST_SET) || (st_q == ST_READ) || (st_q == ST_WRITE);

  always_comb begin
    st_d    = st_q;
    round_d = round_q;
    idx_d   = idx_q;
    ph_d    = ph_q;
    load    = 1'b0;
    step    = 1'b0;
    clr     = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          st_d    = ST_FILL;
          round_d = '0;
          idx_d   = '0;
          ph_d    = 1'b0;
          load    = 1'b1;
          clr     = 1'b1;
        end
      end
      ST_FILL, ST_SET, ST_READ, ST_WRITE: begin
        if (!last) begin
          step = 1'b1;
        end else begin
          load = 1'b1;
          unique case (st_q)
            ST_FILL: begin
              st_d  = ST_READ;
              ph_d  = 1'b0;
              idx_d = '0;
            end
            ST_SET:   st_d = ST_READ;
            ST_WRITE: st_d = ST_READ;
            default: begin
              if (!ph_q) begin
                if (idx_q == IDX_LAST) begin
                  st_d = ST_SET;
                  ph_d = 1'b1;
                end else begin
                  st_d  = ST_WRITE;
                  idx_d = idx_q + 4'd1;
                end
              end else if (idx_q == '0) begin
                if (round_q == LAST_ROUND) begin
                  st_d = ST_DRAIN;
                  load = 1'b0;
                end else begin
                  st_d    = ST_FILL;
                  round_d = round_q + 3'd1;
                  ph_d    = 1'b0;
                end
              end else begin
                st_d  = ST_WRITE;
                idx_d = idx_q - 4'd1;
              end
            end
          endcase
        end
      end
      ST_DRAIN: st_d = ST_DONE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      round_q <= '0;
      idx_q   <= '0;
      ph_q    <= 1'b0;
      wval_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      round_q <= round_d;
      idx_q   <= idx_d;
      ph_q    <= ph_d;
      if (load) wval_q <= gs_val;
    end
  end

  // sweep descriptor is derived from the next state so sweeps abut
  nbp_gray_step u_gray (
    .round_i  (round_d),
    .idx_i    (idx_d),
    .rising_i (!ph_d),
    .label_o  (gs_label),
    .value_o  (gs_val)
  );

  assign walk_full  = (st_d == ST_FILL);
  assign walk_label = (st_d == ST_WRITE) ? gs_label : round_d;

  nbp_cell_walker #(.ROWS(ROWS), .COLS(COLS), .AW(AW)) u_walk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .full_i  (walk_full),
    .label_i (walk_label),
    .addr_o  (mem_addr_o),
    .last_o  (last)
  );

  assign mem_we_o    = (st_q == ST_FILL) || (st_q == ST_SET) || (st_q == ST_WRITE);
  assign mem_re_o    = (st_q == ST_READ);
  assign mem_wdata_o = (st_q == ST_SET) || ((st_q == ST_WRITE) && wval_q);
  assign busy_o      = op_act || (st_q == ST_DRAIN);
  assign done_o      = (st_q == ST_DONE);

  nbp_read_check #(.AW(AW)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .re_i        (mem_re_o),
    .exp_i       (ph_q),
    .addr_i      (mem_addr_o),
    .rdata_i     (mem_rdata_i),
    .fail_o      (fail_o),
    .fail_addr_o (fail_addr_o)
  );

  assert_addr_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o) |-> (int'(mem_addr_o) < int'(CELLS)));

  assert_busy_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && st_q != ST_DRAIN) |=> busy_o);

  assert_drain_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DRAIN) |=> (done_o && !busy_o));

  assert_round_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && round_q != $past(round_q)) |-> (round_q == $past(round_q) + 3'd1));
endmodule

// File: tb/tb_nbr_pattern_bist.sv
module tb_nbr_pattern_bist;
  localparam int ROWS       = 6;
  localparam int COLS       = 7;
  localparam int CELLS      = ROWS * COLS;
  localparam int AW         = $clog2(CELLS);
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] addr;
  logic          we, re, wdata;
  logic          rdata = 1'b0;
  logic          busy, done, fail;
  logic [AW-1:0] fail_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit closed = 0;

  int    q_we[$], q_addr[$], q_val[$];
  string q_tag[$];

  logic mem [CELLS];
  int   fault_mode = 0;
  int   fault_addr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nbr_pattern_bist #(.ROWS(ROWS), .COLS(COLS)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .mem_addr_o  (addr),
    .mem_we_o    (we),
    .mem_re_o    (re),
    .mem_wdata_o (wdata),
    .mem_rdata_i (rdata),
    .busy_o      (busy),
    .done_o      (done),
    .fail_o      (fail),
    .fail_addr_o (fail_addr)
  );

  // 1 = stuck at 1, 2 = stuck at 0, 3 = reads 0 when it and all four neighbours hold 1
  function automatic logic fault_view(input logic arr [CELLS], input int a);
    int   r = a / COLS;
    int   c = a % COLS;
    logic v = arr[a];
    if (a != fault_addr) return v;
    case (fault_mode)
      1: return 1'b1;
      2: return 1'b0;
      3: begin
        if (v && r > 0 && r < ROWS-1 && c > 0 && c < COLS-1 &&
            arr[a-COLS] && arr[a+COLS] && arr[a-1] && arr[a+1]) return 1'b0;
        return v;
      end
      default: return v;
    endcase
  endfunction

  always @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= fault_view(mem, int'(addr));
  end

  function automatic int gray(input int j);
    return j ^ (j >> 1);
  endfunction

  task automatic push_op(input int w, input int a, input int v, input string tag);
    q_we.push_back(w);
    q_addr.push_back(a);
    q_val.push_back(v);
    q_tag.push_back(tag);
  endtask

  // R3 label = (r + 2c) mod 5; R5 only in-grid cells, ascending address
  task automatic sweep(input int lab, input int w, input int v, input string tag);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if ((r + 2*c) % 5 == lab) begin
          bit edge_cell = (r == 0 || r == ROWS-1 || c == 0 || c == COLS-1);
          push_op(w, r*COLS + c, v, (w != 0 && edge_cell && tag != "R7") ? "R5" : tag);
        end
  endtask

  task automatic build_ops();
    for (int b = 0; b < 5; b++) begin   // R8 rounds in order
      for (int a = 0; a < CELLS; a++) push_op(1, a, 0, (b == 0) ? "R4" : "R8");
      for (int v = 0; v < 2; v++) begin
        if (v == 1) sweep(b, 1, 1, "R7");
        sweep(b, 0, v, "R3");
        for (int s = 1; s < 16; s++) begin
          int from = (v == 0) ? s - 1 : 16 - s;
          int to   = (v == 0) ? s : 15 - s;
          int diff = gray(from) ^ gray(to);
          int p    = 0;
          for (int k = 0; k < 4; k++) if ((diff >> k) & 1) p = k;
          sweep((b + p + 1) % 5, 1, (gray(to) >> p) & 1, (v == 0) ? "R6" : "R7");
          sweep(b, 0, v, "R3");
        end
      end
    end
  endtask

  function automatic int model_first_fail();
    logic arr [CELLS];
    for (int a = 0; a < CELLS; a++) arr[a] = 1'b0;
    for (int i = 0; i < q_we.size(); i++) begin
      if (q_we[i] != 0) arr[q_addr[i]] = q_val[i][0];
      else if (int'(fault_view(arr, q_addr[i])) != q_val[i]) return q_addr[i];
    end
    return -1;
  endfunction

  task automatic chk(input int got, input int exp, input string tag, input string what);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic close_run();
    if (!closed) begin
      closed = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic run_case(input int mode, input int faddr, input int known,
                          input bit poke, input bit chk_clear, input string name);
    int exp_fail;
    fault_mode = mode;
    fault_addr = faddr;
    exp_fail   = model_first_fail();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (chk_clear) begin
      chk(int'(fail), 0, "R10", {name, " fail cleared"});
      chk(int'(fail_addr), 0, "R10", {name, " fail address cleared"});
    end
    for (int i = 0; i < q_we.size(); i++) begin
      int got = (int'(busy) << 9) | (int'(we) << 8) | (int'(re) << 7) | (int'(addr) << 1) |
                (we ? int'(wdata) : 0);
      int exp = (1 << 9) | ((q_we[i] != 0) ? (1 << 8) : (1 << 7)) | (q_addr[i] << 1) |
                ((q_we[i] != 0) ? q_val[i] : 0);
      chk(got, exp, q_tag[i], $sformatf("%s op %0d", name, i));
      start = (poke && i == 57);   // R2 start while busy is ignored
      @(negedge clk);
    end
    start = 1'b0;
    chk((int'(busy) << 3) | (int'(done) << 2) | (int'(we) << 1) | int'(re), 8, "R2", {name, " drain cycle"});
    @(negedge clk);
    chk((int'(busy) << 1) | int'(done), 1, "R2", {name, " done"});
    chk(int'(fail), (exp_fail >= 0) ? 1 : 0, "R9", {name, " fail flag"});
    if (known >= 0) chk(int'(fail_addr), known, "R9", {name, " first failing address"});
    @(negedge clk);
    chk(int'(done), 1, "R2", {name, " done held"});
  endtask

  initial begin
    for (int a = 0; a < CELLS; a++) mem[a] = 1'b0;
    build_ops();
    repeat (3) @(negedge clk);
    chk((int'(busy) << 4) | (int'(done) << 3) | (int'(fail) << 2) | (int'(we) << 1) | int'(re),
        0, "R1", "reset outputs");
    rst_n = 1'b1;
    @(negedge clk);
    chk((int'(busy) << 4) | (int'(done) << 3) | (int'(fail) << 2) | (int'(we) << 1) | int'(re),
        0, "R1", "idle after release");

    run_case(0, 0, -1, 1'b1, 1'b0, "clean");
    run_case(1, 0, 0, 1'b0, 1'b0, "stuck1_corner");
    run_case(3, 3*COLS + 3, 3*COLS + 3, 1'b0, 1'b1, "neighbour_fault");
    run_case(2, CELLS-1, CELLS-1, 1'b0, 1'b1, "stuck0_corner");
    run_case(0, 0, -1, 1'b0, 1'b1, "clean_again");

    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (40) @(negedge clk);
    chk(int'(busy), 1, "R2", "busy before reset");
    rst_n = 1'b0;
    #1;
    chk((int'(busy) << 4) | (int'(done) << 3) | (int'(fail) << 2) | (int'(we) << 1) | int'(re),
        0, "R1", "reset mid-run");
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(int'(busy), 0, "R1", "idle after mid-run reset");
    close_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    close_run();
  end
endmodule